// File: doc/BRIEF.md
# SECDED-Protected Word RAM with Check-Bit Diagnostics

The block is a small word-addressed RAM that stores a 7-bit SECDED code next to every 32-bit data word. A simple single-cycle register bus reaches the data words, a block of control and status registers, and, while test mode is on, an alias window where the check bits can be read and overwritten. Reads return one cycle after the request. The check, the optional single-bit repair and the status update all happen in that response cycle.

Every enable is a 4-bit key: 0xA means on, 0x5 means off, and any other value counts as off and is flagged. With detection off, data writes leave the stored check bits untouched. Software can therefore plant a single-bit or double-bit error, turn detection back on and confirm that the error logic reacts. Single-bit errors raise a sticky flag and an optional event pulse. Double-bit errors raise a separate sticky flag and their own event pulse. The word index of the first error is held until software clears the flags.

Top module: `secded_ram`

## Requirements
- R1: A data write at byte address 4*i (window bits [11:10]=00) stores the word. A read of that address returns it with rsp_valid high in the cycle after the request and low otherwise. The evt_sbe and evt_dbe outputs are only ever high in a cycle where rsp_valid is high.
- R2: The control register sits at 0x800: det key [3:0], test bit [8], correction key [19:16], single-error event key [27:24]. It resets to 0x050A0005. The diagnostic register sits at 0x804 with its key in [3:0] and resets to 0xA. Both read back the values written to them.
- R3: Only det key 0xA turns checking on. Under any other det value, reads return the raw stored word with no events and no status change, and data writes keep the old check bits.
- R4: While test bit [8] is 1, the check bits of word i read at 0x400+4*i in bits [6:0], and bits [31:7] read as zero. While it is 0, that window reads 0 and writes to it are ignored.
- R5: A write into the check window updates the check bits only when the diagnostic key is 0x5.
- R6: The check code is a Hamming(38,32) syndrome in check bits [5:0] plus an overall parity bit [6]. When checking is on, a single flipped data or check bit is detected and, with correction key 0xA, the read returns the original data.
- R7: With correction key 0x5, a word holding a single-bit error is returned uncorrected. It is still flagged.
- R8: evt_sbe pulses on a detected single-bit error only while the event key is 0xA. Under 0x5 no pulse appears, but the status flag still sets.
- R9: A detected double-bit error pulses evt_dbe, not evt_sbe, and returns the stored word unchanged.
- R10: The status register at 0x808 holds sticky flags: single [0], double [1], key error [2]. Writing 1 to a bit clears it.
- R11: The register at 0x80C holds the word index of the first error detected while both error flags were clear. It holds that value until those flags are cleared.
- R12: Writing a key field of the control or diagnostic register with a value other than 0xA or 0x5 sets status bit [2]. The field acts as off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 12 | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after the read request |
| rsp_rdata | output | 32 | Read data |
| evt_sbe | output | 1 | Single-bit error event pulse |
| evt_dbe | output | 1 | Double-bit (uncorrectable) error event pulse |

## Verification
Suppose a key decode or the write path of the check bits goes wrong. A clean word then reads back with a spurious event, or a planted error goes unnoticed, on the first response after the fault. Syndrome or repair faults show up as wrong data in that same response cycle. A bad status or address capture only shows on the next register read, so the bench reads status and the error index after every injected error. It also reads the check window directly, to show whether a write was allowed to land.

// File: rtl/secded_pkg.sv
package secded_pkg;
    localparam int DATA_W = 32;
    localparam int HAM_W  = 6;
    localparam int CHK_W  = HAM_W + 1;
    localparam int CODE_N = DATA_W + HAM_W;

    localparam logic [3:0] KEY_ON  = 4'hA;
    localparam logic [3:0] KEY_OFF = 4'h5;

    typedef enum logic [1:0] {SEL_DATA, SEL_CHECK, SEL_REG} rsel_e;

    function automatic logic key_valid(input logic [3:0] k);
        return (k == KEY_ON) || (k == KEY_OFF);
    endfunction

    // syndrome bits: data occupies the non-power-of-two positions 3..38
    function automatic logic [HAM_W-1:0] ham_bits(input logic [DATA_W-1:0] d);
        logic [HAM_W-1:0] h;
        int k;
        h = '0;
        k = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                for (int i = 0; i < HAM_W; i++)
                    if (p[i]) h[i] = h[i] ^ d[k];
                k++;
            end
        end
        return h;
    endfunction

    function automatic logic [DATA_W-1:0] flip_at(input logic [DATA_W-1:0] d,
                                                  input logic [HAM_W-1:0] pos);
        logic [DATA_W-1:0] r;
        int k;
        r = d;
        k = 0;
        for (int p = 1; p <= CODE_N; p++) begin
            if ((p & (p - 1)) != 0) begin
                if (p == int'(pos)) r[k] = ~r[k];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/secded_enc.sv
module secded_enc
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    output logic [CHK_W-1:0]  check
);
    logic [HAM_W-1:0] ham;
    always_comb begin
        ham   = ham_bits(data);
        check = {(^data) ^ (^ham), ham};
    end
endmodule

// File: rtl/secded_dec.sv
module secded_dec
    import secded_pkg::*;
(
    input  logic [DATA_W-1:0] data,
    input  logic [CHK_W-1:0]  check,
    output logic [DATA_W-1:0] fixed,
    output logic              single,
    output logic              double
);
    logic [HAM_W-1:0] syn;
    logic             perr;
    logic             in_range;
    always_comb begin
        syn      = ham_bits(data) ^ check[HAM_W-1:0];
        perr     = ^{data, check};
        in_range = int'(syn) <= CODE_N;
        single   = perr && in_range;
        double   = (!perr && syn != '0) || (perr && !in_range);
        fixed    = single ? flip_at(data, syn) : data;
    end
endmodule

// File: rtl/secded_store.sv
module secded_store
    import secded_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic              clk,
    input  logic              rd_en,
    input  logic [AW-1:0]     idx,
    input  logic              data_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic              check_we,
    input  logic [CHK_W-1:0]  wcheck,
    output logic [DATA_W-1:0] rdata_q,
    output logic [CHK_W-1:0]  rcheck_q
);
    logic [DATA_W-1:0] data_mem  [DEPTH];
    logic [CHK_W-1:0]  check_mem [DEPTH];

    always_ff @(posedge clk) begin
        if (data_we)  data_mem[idx]  <= wdata;
        if (check_we) check_mem[idx] <= wcheck;
        if (rd_en) begin
            rdata_q  <= data_mem[idx];
            rcheck_q <= check_mem[idx];
        end
    end
endmodule

// File: rtl/secded_ram.sv
module secded_ram
    import secded_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = $clog2(DEPTH)
)(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        req_valid,
    input  logic        req_write,
    input  logic [11:0] req_addr,
    input  logic [31:0] req_wdata,
    output logic        rsp_valid,
    output logic [31:0] rsp_rdata,
    output logic        evt_sbe,
    output logic        evt_dbe
);
    typedef struct packed {
        logic [3:0]  det;
        logic        test;
        logic [3:0]  corr;
        logic [3:0]  sbe_key;
        logic [3:0]  diag;
        logic        st_sbe;
        logic        st_dbe;
        logic        st_key;
        logic [AW-1:0] err_idx;
        logic        rsp_v;
        rsel_e       rsel;
        logic [31:0] reg_rd;
    } state_t;

    state_t s_q, s_d;

    logic              wr, rd, in_data, in_check, in_reg, clr;
    logic [AW-1:0]     idx;
    logic              data_we, check_we, rd_en;
    logic [CHK_W-1:0]  enc_check, wcheck;
    logic [DATA_W-1:0] mem_data, dec_fixed;
    logic [CHK_W-1:0]  mem_check;
    logic              dec_single, dec_double;
    logic              chk_on, sbe_hit, dbe_hit;
    logic              sbe_flag, dbe_flag;
    logic              unused_bits;

    assign unused_bits = ^{req_addr[9:AW+2], req_addr[1:0]};

    always_comb begin
        wr       = req_valid && req_write;
        rd       = req_valid && !req_write;
        in_data  = req_addr[11:10] == 2'b00;
        in_check = req_addr[11:10] == 2'b01;
        in_reg   = req_addr[11:10] == 2'b10;
        idx      = req_addr[AW+1:2];
        chk_on   = s_q.det == KEY_ON;
        data_we  = wr && in_data;
        check_we = (wr && in_data && chk_on) ||
                   (wr && in_check && s_q.test && s_q.diag == KEY_OFF);
        wcheck   = in_data ? enc_check : req_wdata[CHK_W-1:0];
        rd_en    = rd && (in_data || in_check);
        clr      = wr && in_reg && req_addr[3:2] == 2'd2;
    end

    secded_enc u_enc (.data(req_wdata), .check(enc_check));

    secded_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rd_en(rd_en), .idx(idx),
        .data_we(data_we), .wdata(req_wdata),
        .check_we(check_we), .wcheck(wcheck),
        .rdata_q(mem_data), .rcheck_q(mem_check)
    );

    secded_dec u_dec (
        .data(mem_data), .check(mem_check), .fixed(dec_fixed),
        .single(dec_single), .double(dec_double)
    );

    // response side
    always_comb begin
        sbe_hit   = s_q.rsp_v && s_q.rsel == SEL_DATA && chk_on && dec_single;
        dbe_hit   = s_q.rsp_v && s_q.rsel == SEL_DATA && chk_on && dec_double;
        rsp_valid = s_q.rsp_v;
        evt_sbe   = sbe_hit && s_q.sbe_key == KEY_ON;
        evt_dbe   = dbe_hit;
        case (s_q.rsel)
            SEL_DATA:  rsp_rdata = (chk_on && s_q.corr == KEY_ON) ? dec_fixed : mem_data;
            SEL_CHECK: rsp_rdata = {{(32-CHK_W){1'b0}}, mem_check};
            default:   rsp_rdata = s_q.reg_rd;
        endcase
        sbe_flag = s_q.st_sbe;
        dbe_flag = s_q.st_dbe;
    end

    // next state
    always_comb begin
        s_d       = s_q;
        s_d.rsp_v = rd;
        s_d.rsel  = in_data ? SEL_DATA : ((in_check && s_q.test) ? SEL_CHECK : SEL_REG);
        s_d.reg_rd = '0;
        if (in_reg) begin
            case (req_addr[3:2])
                2'd0: s_d.reg_rd = {4'b0, s_q.sbe_key, 4'b0, s_q.corr,
                                    7'b0, s_q.test, 4'b0, s_q.det};
                2'd1: s_d.reg_rd = {28'b0, s_q.diag};
                2'd2: s_d.reg_rd = {29'b0, s_q.st_key, s_q.st_dbe, s_q.st_sbe};
                default: s_d.reg_rd = 32'(s_q.err_idx);
            endcase
        end

        s_d.st_sbe = (s_q.st_sbe && !(clr && req_wdata[0])) || sbe_hit;
        s_d.st_dbe = (s_q.st_dbe && !(clr && req_wdata[1])) || dbe_hit;
        s_d.st_key = s_q.st_key && !(clr && req_wdata[2]);
        if ((sbe_hit || dbe_hit) && !(s_q.st_sbe || s_q.st_dbe))
            s_d.err_idx = mem_idx_q;

        if (wr && in_reg && req_addr[3:2] == 2'd0) begin
            s_d.det     = req_wdata[3:0];
            s_d.test    = req_wdata[8];
            s_d.corr    = req_wdata[19:16];
            s_d.sbe_key = req_wdata[27:24];
            if (!key_valid(req_wdata[3:0]) || !key_valid(req_wdata[19:16]) ||
                !key_valid(req_wdata[27:24]))
                s_d.st_key = 1'b1;
        end
        if (wr && in_reg && req_addr[3:2] == 2'd1) begin
            s_d.diag = req_wdata[3:0];
            if (!key_valid(req_wdata[3:0])) s_d.st_key = 1'b1;
        end
    end

    logic [AW-1:0] mem_idx_q;
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mem_idx_q <= '0;
        else if (rd_en) mem_idx_q <= idx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q         <= '0;
            s_q.det     <= KEY_OFF;
            s_q.corr    <= KEY_ON;
            s_q.sbe_key <= KEY_OFF;
            s_q.diag    <= KEY_ON;
            s_q.rsel    <= SEL_REG;
        end else begin
            s_q <= s_d;
        end
    end
endmodule

module secded_ram_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        req_valid,
    input logic        req_write,
    input logic [11:0] req_addr,
    input logic [31:0] req_wdata,
    input logic        rsp_valid,
    input logic        evt_sbe,
    input logic        evt_dbe,
    input logic        sbe_flag,
    input logic        dbe_flag
);
    AST_RSP_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid && !req_write)); // R1
    AST_EVT_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_sbe || evt_dbe) |-> rsp_valid); // R1
    AST_DBE_NOT_SBE: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dbe |-> !evt_sbe); // R9
    AST_SBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_sbe |=> sbe_flag); // R8
    AST_DBE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        evt_dbe |=> dbe_flag); // R10
    AST_SBE_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sbe_flag) |-> $past(req_valid && req_write && req_addr == 12'h808 && req_wdata[0])); // R10
    AST_DBE_CLEAR_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dbe_flag) |-> $past(req_valid && req_write && req_addr == 12'h808 && req_wdata[1])); // R10
endmodule

bind secded_ram secded_ram_chk u_chk (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .evt_sbe(evt_sbe), .evt_dbe(evt_dbe), .sbe_flag(sbe_flag), .dbe_flag(dbe_flag)
);

// File: tb/secded_ram_test.sv
module secded_ram_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_write = 1'b0;
    logic [11:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid, evt_sbe, evt_dbe;
    logic [31:0] rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    typedef struct {
        logic [31:0] data;
        logic        sbe;
        logic        dbe;
        bit          cmp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #5 clk = ~clk;

    secded_ram uut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
        .rsp_rdata(rsp_rdata), .evt_sbe(evt_sbe), .evt_dbe(evt_dbe)
    );

    // monitor: compare every response against the oldest queued expectation
    always @(negedge clk) begin
        if (rst_n && rsp_valid) begin
            if (sb.size() == 0) begin
                checks++; failures++;
                $display("FAIL R1 unexpected response actual=%h expected=none", rsp_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (it.cmp) begin
                    checks++;
                    if (rsp_rdata !== it.data || evt_sbe !== it.sbe || evt_dbe !== it.dbe) begin
                        failures++;
                        $display("FAIL %s actual=%h/%b/%b expected=%h/%b/%b", it.tag,
                                 rsp_rdata, evt_sbe, evt_dbe, it.data, it.sbe, it.dbe);
                    end
                end
            end
        end
        if (rst_n && !rsp_valid && (evt_sbe || evt_dbe)) begin
            checks++; failures++;
            $display("FAIL R1 event without response actual=%b%b expected=00", evt_sbe, evt_dbe);
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
        @(negedge clk);
        req_valid = 0; req_write = 0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] e,
                      input logic es, input logic ed, input string tag);
        item_t it;
        it.data = e; it.sbe = es; it.dbe = ed; it.cmp = 1; it.tag = tag;
        sb.push_back(it);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
    endtask

    task automatic rd_raw(input logic [11:0] a, output logic [31:0] v);
        item_t it;
        it.data = '0; it.sbe = 0; it.dbe = 0; it.cmp = 0; it.tag = "";
        sb.push_back(it);
        req_valid = 1; req_write = 0; req_addr = a;
        @(negedge clk);
        req_valid = 0;
        v = rsp_rdata;
    endtask

    task automatic idle();
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [31:0] chk1, chk0, v;
        repeat (3) @(negedge clk);
        rst_n = 1;
        idle();
        // reset values
        rd(12'h800, 32'h050A0005, 0, 0, "R2 ctrl reset");
        rd(12'h804, 32'h0000000A, 0, 0, "R2 diag reset");
        rd(12'h808, 32'h0, 0, 0, "R10 status reset");
        // basic store
        wr(12'h800, 32'h0A0A000A);
        rd(12'h800, 32'h0A0A000A, 0, 0, "R2 ctrl readback");
        wr(12'h000, 32'h12345678);
        wr(12'h004, 32'hDEADBEEF);
        wr(12'h008, 32'h0F0F00FF);
        wr(12'h00C, 32'hA5A5C3C3);
        rd(12'h000, 32'h12345678, 0, 0, "R1 word0");
        rd(12'h004, 32'hDEADBEEF, 0, 0, "R1 word1");
        rd(12'h008, 32'h0F0F00FF, 0, 0, "R1 word2");
        rd(12'h00C, 32'hA5A5C3C3, 0, 0, "R1 word3");
        // check window
        wr(12'h800, 32'h0A0A010A);
        wr(12'h804, 32'h5);
        rd_raw(12'h404, chk1);
        checks++;
        if ((chk1 >> 7) != 0) begin
            failures++;
            $display("FAIL R4 upper check bits actual=%h expected=0", chk1 >> 7);
        end
        // single error in a check bit
        wr(12'h404, chk1 ^ 32'h1);
        rd(12'h004, 32'hDEADBEEF, 1, 0, "R6 check-bit flip corrected");
        idle();
        rd(12'h808, 32'h1, 0, 0, "R10 sbe flag");
        rd(12'h80C, 32'h1, 0, 0, "R11 first error index");
        // event off, clear, re-detect
        wr(12'h800, 32'h050A010A);
        wr(12'h808, 32'h1);
        rd(12'h808, 32'h0, 0, 0, "R10 w1c clear");
        rd(12'h004, 32'hDEADBEEF, 0, 0, "R8 event key off");
        idle();
        rd(12'h808, 32'h1, 0, 0, "R8 flag set without event");
        wr(12'h404, chk1);
        rd(12'h004, 32'hDEADBEEF, 0, 0, "R5 restored check bits");
        // plant data error with detection off
        wr(12'h800, 32'h0A0A0105);
        wr(12'h008, 32'h0F0F00DF);
        wr(12'h800, 32'h0A05010A);
        rd(12'h008, 32'h0F0F00DF, 1, 0, "R7 correction off raw data");
        wr(12'h800, 32'h0A0A010A);
        rd(12'h008, 32'h0F0F00FF, 1, 0, "R3 planted error corrected");
        idle();
        rd(12'h80C, 32'h1, 0, 0, "R11 index held while flag set");
        // double error
        wr(12'h808, 32'h7);
        wr(12'h800, 32'h0A0A0105);
        wr(12'h00C, 32'hA5A5C3C0);
        wr(12'h800, 32'h0A0A010A);
        rd(12'h00C, 32'hA5A5C3C0, 0, 1, "R9 double error");
        idle();
        rd(12'h808, 32'h2, 0, 0, "R9 dbe flag");
        rd(12'h80C, 32'h3, 0, 0, "R11 new index after clear");
        // diag lock
        rd_raw(12'h400, chk0);
        wr(12'h804, 32'hA);
        wr(12'h400, chk0 ^ 32'h3);
        rd(12'h000, 32'h12345678, 0, 0, "R5 locked check write ignored");
        rd(12'h400, chk0, 0, 0, "R5 check bits unchanged");
        // test bit off
        wr(12'h804, 32'h5);
        wr(12'h800, 32'h0A0A000A);
        rd(12'h400, 32'h0, 0, 0, "R4 window closed reads zero");
        wr(12'h400, 32'h0);
        wr(12'h800, 32'h0A0A010A);
        rd(12'h400, chk0, 0, 0, "R4 closed window write ignored");
        // detection off read
        wr(12'h800, 32'h0A0A0005);
        rd(12'h00C, 32'hA5A5C3C0, 0, 0, "R3 detection off raw no event");
        idle();
        rd(12'h808, 32'h2, 0, 0, "R3 status unchanged");
        // bad key
        wr(12'h800, 32'h0A0A0003);
        rd(12'h00C, 32'hA5A5C3C0, 0, 0, "R12 bad det key acts off");
        idle();
        rd(12'h808, 32'h6, 0, 0, "R12 key error flag");
        // regenerate on write
        wr(12'h800, 32'h0A0A000A);
        wr(12'h00C, 32'h11112222);
        rd(12'h00C, 32'h11112222, 0, 0, "R3 check bits regenerated");
        repeat (3) idle();
        checks++;
        if (sb.size() != 0) begin
            failures++;
            $display("FAIL R1 missing responses actual=%0d expected=0", sb.size());
        end
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule